// File: doc/BRIEF.md
# Token-Passing Readout Sequencer with Analog Power Gating

This block steps one front-end chip through a bunch-train cycle. A cycle-start strobe from the acquisition controller starts it. The block powers up the analog sections and allows a wake-up interval. It then holds an acquisition window and a conversion window, and finally waits for its turn on a data bus shared by a chain of chips. Each phase length is a parameter. The real proportions are roughly 1 ms of acquisition, 0.5 ms of conversion, 0.5 ms of readout and about 199 ms idle, so the analog power is off for nearly the whole cycle.

Bus ownership moves along the chain by a token. The chip that receives the token samples its stored event count. An empty chip hands the token on at once. Otherwise the chip enables the shared data bus and paces out `evt_cnt * EVT_BITS` bits, one bit every `BIT_DIV` clocks, which gives a nominal 5 MHz bit rate at the system clock. After the last bit period it emits a one-cycle token pulse and drops power. The last chip of a chain also reports the end of readout. The analog conversion, the data shifter and the bus driver sit outside this block.

Top module: `ring_readout_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pwr_en`, `data_en`, `bit_stb`, `tok_out` and `ro_done` are 0 and `phase_o` is 0 (idle).
- R2: A `cyc_start` pulse sampled in idle moves the sequencer to wake-up on the next cycle. `pwr_en` is 1 in every phase except idle. `phase_o` encodes idle=0, wake=1, acquire=2, convert=3, wait-for-token=4, send=5.
- R3: The phases follow the order wake, acquire, convert, wait-for-token. Wake, acquire and convert last exactly `WAKE_CYC`, `ACQ_CYC` and `CONV_CYC` cycles.
- R4: `tok_in` is acted on only in wait-for-token. A `tok_in` pulse in any other phase changes neither `phase_o`, `data_en` nor `tok_out`.
- R5: When the token is granted with a non-zero `evt_cnt`, `data_en` is 1 for exactly `evt_cnt*EVT_BITS*BIT_DIV` consecutive cycles. This window starts on the cycle after the grant. `data_en` is 0 at all other times.
- R6: During send, `bit_stb` is 1 on the first cycle of each `BIT_DIV`-cycle bit period. `bit_idx` holds the current bit number, counting from 0 to `evt_cnt*EVT_BITS-1`.
- R7: `tok_out` is a one-cycle pulse. It comes on the cycle after the last send cycle or, when `evt_cnt` is 0 at the grant, on the cycle after the grant, with no `data_en` at all.
- R8: The sequencer returns to idle in the same cycle that `tok_out` is 1, so `pwr_en` is 0 from that cycle on.
- R9: `ro_done` is 1 together with `tok_out` when the parameter `IS_LAST` is 1, and stays 0 when it is 0.
- R10: A `cyc_start` pulse outside idle is ignored and does not disturb the phase or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Cycle-start strobe from the acquisition controller |
| tok_in | input | 1 | Token pulse from the previous chip in the chain |
| evt_cnt | input | EVW | Number of stored events, sampled at token grant |
| pwr_en | output | 1 | Power enable for the analog sections |
| phase_o | output | 3 | Current phase code |
| data_en | output | 1 | Shared data-bus drive enable |
| bit_stb | output | 1 | Start of a bit period |
| bit_idx | output | BITW | Index of the bit being sent |
| tok_out | output | 1 | Token pulse to the next chip |
| ro_done | output | 1 | End-of-readout flag (last chip only) |

## Verification
A phase counter that is off by one moves `phase_o`, and with it the cycle on which a grant can land. The behavioural model catches that on the first cycle of the wrong phase. A bit pacer with a wrong divider or length shows up as a misplaced `bit_stb`, or as a `data_en` window that ends one cycle early or late. The token pulse and the power drop then land on the wrong cycle. A wrong grant or empty decision would show as bus drive or token forwarding outside its turn. The per-clock comparison reports it within one cycle.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAKE = 3'd1,
    PH_ACQ  = 3'd2,
    PH_CONV = 3'd3,
    PH_WAIT = 3'd4,
    PH_SEND = 3'd5
  } phase_t;
endpackage

// File: rtl/rrs_phase_ctl.sv
module rrs_phase_ctl
  import rrs_pkg::*;
#(
  parameter int WAKE_CYC = 5,
  parameter int ACQ_CYC  = 10,
  parameter int CONV_CYC = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   tok_grant,
  input  logic   empty,
  input  logic   send_done,
  output phase_t phase
);
  localparam int MAXD = (WAKE_CYC > ACQ_CYC) ?
                        ((WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC) :
                        ((ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC);
  localparam int CNTW = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CNTW-1:0] cnt;

  // last count value of a timed phase
  function automatic logic [CNTW-1:0] phase_last(input phase_t p);
    case (p)
      PH_WAKE: phase_last = CNTW'(WAKE_CYC - 1);
      PH_ACQ:  phase_last = CNTW'(ACQ_CYC - 1);
      default: phase_last = CNTW'(CONV_CYC - 1);
    endcase
  endfunction

  function automatic phase_t phase_next(input phase_t p);
    case (p)
      PH_WAKE: phase_next = PH_ACQ;
      PH_ACQ:  phase_next = PH_CONV;
      default: phase_next = PH_WAIT;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (cyc_start) begin
          phase <= PH_WAKE;
          cnt   <= '0;
        end
        PH_WAKE, PH_ACQ, PH_CONV: begin
          if (cnt == phase_last(phase)) begin
            phase <= phase_next(phase);
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: if (tok_grant) phase <= empty ? PH_IDLE : PH_SEND;
        PH_SEND: if (send_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrs_bit_pacer.sv
module rrs_bit_pacer #(
  parameter int EVW      = 4,
  parameter int EVT_BITS = 8,
  parameter int BIT_DIV  = 3,
  parameter int BITW     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [EVW-1:0]  evt_cnt,
  input  logic            active,
  output logic            bit_stb,
  output logic [BITW-1:0] bit_idx,
  output logic            last_end
);
  localparam int DIVW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

  logic [DIVW-1:0] div;
  logic [BITW-1:0] last_bit;

  // index of the final bit for a given event count (count must be non-zero)
  function automatic logic [BITW-1:0] final_bit(input logic [EVW-1:0] n);
    final_bit = BITW'(int'(n) * EVT_BITS - 1);
  endfunction

  wire div_wrap = (div == DIVW'(BIT_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div      <= '0;
      bit_idx  <= '0;
      last_bit <= '0;
    end else if (load) begin
      div      <= '0;
      bit_idx  <= '0;
      last_bit <= final_bit(evt_cnt);
    end else if (active) begin
      if (div_wrap) begin
        div     <= '0;
        bit_idx <= bit_idx + 1'b1;
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign bit_stb  = active && (div == '0);
  assign last_end = active && div_wrap && (bit_idx == last_bit);
endmodule

// File: rtl/rrs_token_out.sv
module rrs_token_out #(
  parameter bit IS_LAST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic release_ev,
  output logic tok_out,
  output logic ro_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_out <= 1'b0;
      ro_done <= 1'b0;
    end else begin
      tok_out <= release_ev;
      ro_done <= release_ev & IS_LAST;
    end
  end
endmodule

// File: rtl/ring_readout_seq.sv
module ring_readout_seq
  import rrs_pkg::*;
#(
  parameter int WAKE_CYC = 5,
  parameter int ACQ_CYC  = 10,
  parameter int CONV_CYC = 6,
  parameter int EVW      = 4,
  parameter int EVT_BITS = 8,
  parameter int BIT_DIV  = 3,
  parameter bit IS_LAST  = 1'b0,
  localparam int MAXBITS = ((1 << EVW) - 1) * EVT_BITS,
  localparam int BITW    = $clog2(MAXBITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            tok_in,
  input  logic [EVW-1:0]  evt_cnt,
  output logic            pwr_en,
  output logic [2:0]      phase_o,
  output logic            data_en,
  output logic            bit_stb,
  output logic [BITW-1:0] bit_idx,
  output logic            tok_out,
  output logic            ro_done
);
  phase_t phase;
  logic   send_done;

  // named internal events
  wire empty      = (evt_cnt == '0);
  wire tok_grant  = (phase == PH_WAIT) && tok_in;
  wire send_load  = tok_grant && !empty;
  wire sending    = (phase == PH_SEND);
  wire release_ev = (tok_grant && empty) || send_done;

  rrs_phase_ctl #(
    .WAKE_CYC(WAKE_CYC), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .tok_grant(tok_grant),
    .empty(empty), .send_done(send_done), .phase(phase)
  );

  rrs_bit_pacer #(
    .EVW(EVW), .EVT_BITS(EVT_BITS), .BIT_DIV(BIT_DIV), .BITW(BITW)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(send_load), .evt_cnt(evt_cnt),
    .active(sending), .bit_stb(bit_stb), .bit_idx(bit_idx),
    .last_end(send_done)
  );

  rrs_token_out #(.IS_LAST(IS_LAST)) u_tok (
    .clk(clk), .rst_n(rst_n), .release_ev(release_ev),
    .tok_out(tok_out), .ro_done(ro_done)
  );

  assign pwr_en  = (phase != PH_IDLE);
  assign data_en = sending;
  assign phase_o = phase;
endmodule

// File: rtl/rrs_chk.sv
module rrs_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic tok_in,
  input logic pwr_en,
  input logic data_en,
  input logic bit_stb,
  input logic tok_out,
  input logic ro_done,
  input logic release_ev
);
  // R7
  tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out);
  // R7
  release_to_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> tok_out);
  // R5
  bus_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> pwr_en);
  // R4
  send_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en) |-> $past(tok_in));
  // R6
  stb_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> data_en);
  // R8
  power_off_at_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> !pwr_en);
  // R9
  done_with_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_done |-> tok_out);
  // R2
  power_up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(cyc_start));
endmodule

bind ring_readout_seq rrs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .tok_in(tok_in),
  .pwr_en(pwr_en), .data_en(data_en), .bit_stb(bit_stb), .tok_out(tok_out),
  .ro_done(ro_done), .release_ev(release_ev)
);

// File: tb/tb_ring_readout_seq.sv
module tb_ring_readout_seq;
  localparam int WAKE = 5, ACQ = 10, CONV = 6, EVW = 4, EB = 8, DIV = 3;
  localparam int BITW = $clog2(((1 << EVW) - 1) * EB + 1);

  logic clk = 0, rst_n = 0, cyc_start = 0, tok_in = 0;
  logic [EVW-1:0] evt_cnt = '0;
  logic pwr_en, data_en, bit_stb, tok_out, ro_done;
  logic [2:0] phase_o;
  logic [BITW-1:0] bit_idx;

  ring_readout_seq #(.WAKE_CYC(WAKE), .ACQ_CYC(ACQ), .CONV_CYC(CONV),
    .EVW(EVW), .EVT_BITS(EB), .BIT_DIV(DIV), .IS_LAST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .tok_in(tok_in),
    .evt_cnt(evt_cnt), .pwr_en(pwr_en), .phase_o(phase_o), .data_en(data_en),
    .bit_stb(bit_stb), .bit_idx(bit_idx), .tok_out(tok_out), .ro_done(ro_done));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;

  // behavioural reference: phase code, cycles left, send position, bit count
  int m_ph = 0, m_left = 0, m_t = 0, m_n = 0;
  bit m_tok = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_tok = 0; m_t = 0;
    end else begin
      m_tok = 0;
      case (m_ph)
        0: if (cyc_start) begin m_ph = 1; m_left = WAKE; end
        1, 2, 3: begin
          m_left--;
          if (m_left == 0) begin
            m_ph++;
            m_left = (m_ph == 2) ? ACQ : CONV;
          end
        end
        4: if (tok_in) begin
          m_n = int'(evt_cnt) * EB;
          if (m_n == 0) begin m_ph = 0; m_tok = 1; end
          else begin m_ph = 5; m_t = 0; end
        end
        default: begin
          m_t++;
          if (m_t == m_n * DIV) begin m_ph = 0; m_tok = 1; end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(phase_o == 3'(m_ph), "R3 phase", phase_o, m_ph);
    chk(pwr_en == (m_ph != 0), "R2/R8 pwr_en", pwr_en, m_ph != 0);
    chk(data_en == (m_ph == 5), "R5 data_en", data_en, m_ph == 5);
    chk(bit_stb == (m_ph == 5 && m_t % DIV == 0), "R6 bit_stb", bit_stb,
        m_ph == 5 && m_t % DIV == 0);
    if (m_ph == 5)
      chk(int'(bit_idx) == m_t / DIV, "R6 bit_idx", bit_idx, m_t / DIV);
    chk(tok_out == m_tok, "R7 tok_out", tok_out, m_tok);
    chk(ro_done == m_tok, "R9 ro_done", ro_done, m_tok);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    cyc_start = 1; tick(1); cyc_start = 0;
  endtask

  task automatic pulse_tok();
    tok_in = 1; tick(1); tok_in = 0;
  endtask

  task automatic wait_phase(input int p);
    while (int'(phase_o) != p) tick(1);
  endtask

  task automatic run_cycle(input int evts, input int wait_gap);
    pulse_start();
    wait_phase(4);
    tick(wait_gap);
    evt_cnt = EVW'(evts);
    pulse_tok();
    while (!tok_out) tick(1);
    tick(2);
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk(!pwr_en && !data_en && !bit_stb && !tok_out && !ro_done && phase_o == 0,
        "R1 reset outputs", {pwr_en, data_en, tok_out, phase_o}, 0);
    rst_n = 1;
    tick(1);
    chk(!pwr_en && phase_o == 0, "R1 idle after reset", phase_o, 0);

    // stray token in idle, acquire; stray start in convert
    pulse_tok();
    chk(!data_en && !tok_out && phase_o == 0, "R4 token in idle", data_en, 0);
    pulse_start();
    chk(phase_o == 1, "R2 wake entered", phase_o, 1);
    wait_phase(2);
    evt_cnt = 4'd3;
    pulse_tok();
    chk(!data_en && !tok_out && phase_o == 2, "R4 token in acquire", phase_o, 2);
    wait_phase(3);
    pulse_start();
    chk(phase_o == 3, "R10 start ignored", phase_o, 3);
    wait_phase(4);
    tick(4);
    pulse_tok();
    chk(data_en, "R5 send starts", data_en, 1);
    while (!tok_out) tick(1);
    chk(!pwr_en && ro_done, "R8 power off at pass", pwr_en, 0);
    tick(2);

    // empty chip
    pulse_start();
    wait_phase(4);
    evt_cnt = 4'd0;
    pulse_tok();
    chk(tok_out && !data_en, "R7 empty forwards at once", tok_out, 1);
    tick(2);

    run_cycle(15, 0);
    run_cycle(1, 7);
    run_cycle(2, 1);

    // reset mid-send
    pulse_start();
    wait_phase(4);
    evt_cnt = 4'd5;
    pulse_tok();
    tick(10);
    rst_n = 0;
    tick(2);
    chk(!pwr_en && !data_en && phase_o == 0, "R1 reset mid-send", phase_o, 0);
    rst_n = 1;
    tick(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule